// File: doc/BRIEF.md
# Bus Slave Access Firewall

This block sits in front of one slave port of a memory-mapped bus and checks each request before the slave sees it. A request carries an address, a read/write direction and a 2-bit transfer format code. The upper bits of the address select a slot in a region table, which is fixed at build time. Each valid slot points to one policy word in a small policy store. The rule check compares the request with that policy and drives a pass/deny signal. Allowed requests go straight through to the slave port. Denied requests are absorbed by the firewall, which answers them with its own error response and raises a one-cycle attack pulse toward a monitor.

A trusted controller rewrites the policies through a configuration port. While it holds the hold input high, the firewall stalls all traffic by keeping both request handshakes inactive. It stores nothing in the meantime. Each policy write takes one cycle. Policy word layout: bits [1:0] are the access rights, bits [3:2] are the highest permitted format code, bit [4] quarantines the slave, and bits [31:5] are reserved.

Both request sides and the error-response side use valid/ready. A request is taken when s_valid and s_ready are both high at a clock edge. Back-pressure on an allowed request comes from m_ready. Back-pressure on a denied request comes from a pending, unaccepted error response. An error response stays valid and unchanged until dny_ready is seen.

Top module: `bus_fw_gate`

## Requirements
- R1: An allowed request goes to the slave side in the same cycle: m_valid is high, m_addr, m_write and m_fmt copy the request, and s_ready equals m_ready.
- R2: Rights field bits [1:0]: 00 allows nothing, 01 allows reads only, 10 allows writes only, 11 allows both. s_write is 1 for a write.
- R3: Format field bits [3:2] is the highest allowed format code. A request whose s_fmt is greater than this field is denied.
- R4: When policy bit [4] (quarantine) is 1, every request to a region using that policy is denied, whatever the other fields hold.
- R5: Address bits [11:9] select a region slot. With the default table, slots 0 to 3 use policies 0 to 3, slot 4 shares policy 1, and slots 5 to 7 are unmapped. A request to an unmapped slot is denied.
- R6: A denied request never raises m_valid. It is accepted when no error response is pending, or when the pending one is taken in the same cycle. From the next cycle it produces dny_valid with dny_resp = 2'b10, dny_rdata = 0 and dny_write equal to the request's direction. These values are held until dny_ready.
- R7: attack is high for exactly the one cycle after each accepted denied request, and low at all other times.
- R8: While cfg_hold is high, m_valid and s_ready are low. No request is accepted, denied or flagged.
- R9: A policy write with cfg_we and cfg_hold both high takes one cycle. It governs requests from the next cycle on, so N policies are replaced in N consecutive cycles.
- R10: cfg_we while cfg_hold is low leaves every policy unchanged.
- R11: After reset every policy allows reads and writes of any format with quarantine off, no error response is pending and attack is low.
- R12: A policy word written with any of bits [31:5] set is stored with quarantine on, so a malformed word fails closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Incoming request valid |
| s_ready | output | 1 | Incoming request accepted |
| s_addr | input | 12 | Request address |
| s_write | input | 1 | 1 = write, 0 = read |
| s_fmt | input | 2 | Transfer format code |
| m_valid | output | 1 | Forwarded request valid |
| m_ready | input | 1 | Slave ready |
| m_addr | output | 12 | Forwarded address |
| m_write | output | 1 | Forwarded direction |
| m_fmt | output | 2 | Forwarded format code |
| chk_pass | output | 1 | Current request passes the policy |
| dny_valid | output | 1 | Error response valid |
| dny_ready | input | 1 | Error response taken |
| dny_write | output | 1 | Direction of the denied request |
| dny_resp | output | 2 | Response code, 2'b10 |
| dny_rdata | output | 32 | Read data, always zero |
| cfg_hold | input | 1 | Update in progress; stalls traffic |
| cfg_we | input | 1 | Policy write strobe |
| cfg_idx | input | 2 | Policy index to write |
| cfg_word | input | 32 | Policy word |
| attack | output | 1 | One-cycle deny pulse |

## Verification
The in-line assertions check the handshake rules on every cycle. They cover the stall during an update, the rule that denied requests never reach the slave, and that error responses hold steady under back-pressure with a fixed code and zero data. They also check that attack follows only an accepted denial and that the policy store stays still outside a hold. Which request a given policy actually allows can only be shown by the bench scenarios. This covers the rights and format decoding, quarantine, region sharing, unmapped slots, timing of a new policy and fail-closed reserved bits. Each scenario loads known policies and then compares the pass/deny outcome with an expected value.

// File: rtl/bus_fw_pkg.sv
package bus_fw_pkg;

  // Stored policy: quarantine at bit 4, format ceiling at [3:2], rights at [1:0]
  typedef struct packed {
    logic       quar;
    logic [1:0] fmt_max;
    logic [1:0] rights;
  } fw_rule_t;

  localparam int RULE_W = $bits(fw_rule_t);
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // Reserved bits set in a written word force quarantine (fail closed)
  function automatic fw_rule_t word_to_rule(input logic [31:0] w);
    fw_rule_t r;
    r.rights  = w[1:0];
    r.fmt_max = w[3:2];
    r.quar    = w[4] | (|w[31:5]);
    return r;
  endfunction

endpackage

// File: rtl/bus_fw_region_map.sv
module bus_fw_region_map #(
  parameter int SEL_W = 3,
  parameter int IW    = 2,
  parameter logic [(2**SEL_W)*(IW+1)-1:0] MAP = '0
) (
  input  logic [SEL_W-1:0] sel,
  output logic             hit,
  output logic [IW-1:0]    idx
);
  localparam int SLOTS = 2**SEL_W;
  localparam int EW    = IW + 1;

  logic [SLOTS-1:0]  slot_v;
  logic [IW-1:0]     slot_i [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slot_v[k] = MAP[k*EW + IW];
    assign slot_i[k] = MAP[k*EW +: IW];
  end

  always_comb begin
    hit = slot_v[sel];
    idx = slot_i[sel];
  end
endmodule

// File: rtl/bus_fw_policy_store.sv
module bus_fw_policy_store
  import bus_fw_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter logic [RULE_W-1:0] RESET_RULE = 5'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_hold,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [31:0]   cfg_word,
  input  logic [IW-1:0] rd_idx,
  output fw_rule_t      rd_rule
);
  fw_rule_t [DEPTH-1:0] pol_q;
  fw_rule_t             new_rule;

  assign new_rule = word_to_rule(cfg_word);

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        pol_q[i] <= fw_rule_t'(RESET_RULE);
      else if (cfg_hold && cfg_we && (int'(cfg_idx) == i))
        pol_q[i] <= new_rule;
    end
  end

  always_comb begin
    rd_rule = fw_rule_t'(RESET_RULE);
    for (int i = 0; i < DEPTH; i++)
      if (int'(rd_idx) == i) rd_rule = pol_q[i];
  end

  AST_STORE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hold |=> $stable(pol_q)); // R10
endmodule

// File: rtl/bus_fw_rule_check.sv
module bus_fw_rule_check
  import bus_fw_pkg::*;
(
  input  logic     hit,
  input  fw_rule_t rule,
  input  logic     is_write,
  input  logic [1:0] fmt,
  output logic     pass
);
  logic dir_ok;
  logic fmt_ok;

  always_comb begin
    dir_ok = is_write ? rule.rights[1] : rule.rights[0];
    fmt_ok = (fmt <= rule.fmt_max);
    pass   = hit && !rule.quar && dir_ok && fmt_ok;
  end
endmodule

// File: rtl/bus_fw_gate.sv
module bus_fw_gate
  import bus_fw_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 32,
  parameter int SEL_W     = 3,
  parameter int POL_DEPTH = 4,
  localparam int IW       = $clog2(POL_DEPTH),
  parameter logic [(2**SEL_W)*(IW+1)-1:0] REGION_MAP =
    {3'b000, 3'b000, 3'b000, 3'b101, 3'b111, 3'b110, 3'b101, 3'b100},
  parameter logic [4:0] RESET_RULE = 5'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [AW-1:0] s_addr,
  input  logic          s_write,
  input  logic [1:0]    s_fmt,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [AW-1:0] m_addr,
  output logic          m_write,
  output logic [1:0]    m_fmt,
  output logic          chk_pass,
  output logic          dny_valid,
  input  logic          dny_ready,
  output logic          dny_write,
  output logic [1:0]    dny_resp,
  output logic [DW-1:0] dny_rdata,
  input  logic          cfg_hold,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [31:0]   cfg_word,
  output logic          attack
);
  logic          reg_hit;
  logic [IW-1:0] reg_idx;
  fw_rule_t      cur_rule;
  logic          deny_fire;

  bus_fw_region_map #(.SEL_W(SEL_W), .IW(IW), .MAP(REGION_MAP)) u_map (
    .sel (s_addr[AW-1 -: SEL_W]),
    .hit (reg_hit),
    .idx (reg_idx)
  );

  bus_fw_policy_store #(.DEPTH(POL_DEPTH), .IW(IW), .RESET_RULE(RESET_RULE)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_hold (cfg_hold),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_word (cfg_word),
    .rd_idx   (reg_idx),
    .rd_rule  (cur_rule)
  );

  bus_fw_rule_check u_chk (
    .hit      (reg_hit),
    .rule     (cur_rule),
    .is_write (s_write),
    .fmt      (s_fmt),
    .pass     (chk_pass)
  );

  // Handshake gating: an update freezes both request handshakes
  always_comb begin
    s_ready   = !cfg_hold && (chk_pass ? m_ready : (!dny_valid || dny_ready));
    m_valid   = s_valid && chk_pass && !cfg_hold;
    m_addr    = s_addr;
    m_write   = s_write;
    m_fmt     = s_fmt;
    deny_fire = s_valid && s_ready && !chk_pass;
    dny_resp  = RESP_SLVERR;
    dny_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dny_valid <= 1'b0;
      dny_write <= 1'b0;
      attack    <= 1'b0;
    end else begin
      attack <= deny_fire;
      if (deny_fire) begin
        dny_valid <= 1'b1;
        dny_write <= s_write;
      end else if (dny_ready) begin
        dny_valid <= 1'b0;
      end
    end
  end

  AST_PASS_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && chk_pass && !cfg_hold) |-> (m_valid && s_ready == m_ready)); // R1
  AST_QUAR_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    cur_rule.quar |-> !chk_pass); // R4
  AST_DENY_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_pass |-> !m_valid); // R6
  AST_DNY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dny_valid && !dny_ready) |=> (dny_valid && $stable(dny_write))); // R6
  AST_DNY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    dny_valid |-> (dny_resp == 2'b10 && dny_rdata == '0)); // R6
  AST_ATTACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    attack |-> $past(s_valid && s_ready && !chk_pass)); // R7
  AST_HOLD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold |-> (!m_valid && !s_ready)); // R8
endmodule

// File: tb/bus_fw_gate_tb.sv
module bus_fw_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_ready, s_write = 1'b0;
  logic [11:0] s_addr = '0, m_addr;
  logic [1:0]  s_fmt = '0, m_fmt, dny_resp;
  logic        m_valid, m_ready = 1'b1, m_write, chk_pass;
  logic        dny_valid, dny_ready = 1'b1, dny_write;
  logic [31:0] dny_rdata, cfg_word = '0;
  logic        cfg_hold = 1'b0, cfg_we = 1'b0, attack;
  logic [1:0]  cfg_idx = '0;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  bus_fw_gate u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_write(s_write), .s_fmt(s_fmt),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_write(m_write), .m_fmt(m_fmt),
    .chk_pass(chk_pass),
    .dny_valid(dny_valid), .dny_ready(dny_ready), .dny_write(dny_write),
    .dny_resp(dny_resp), .dny_rdata(dny_rdata),
    .cfg_hold(cfg_hold), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word),
    .attack(attack)
  );

  // {addr[11:0], write, fmt[1:0], expected pass}
  localparam logic [15:0] VECS [0:13] = '{
    {12'h010, 1'b0, 2'd2, 1'b1},  // R2 idx0 read
    {12'h020, 1'b1, 2'd3, 1'b1},  // R2 idx0 write
    {12'h210, 1'b0, 2'd1, 1'b1},  // R3 idx1 fmt at ceiling
    {12'h210, 1'b0, 2'd2, 1'b0},  // R3 fmt above ceiling
    {12'h210, 1'b1, 2'd0, 1'b0},  // R2 read-only refuses write
    {12'h400, 1'b1, 2'd3, 1'b1},  // R2 write-only write
    {12'h400, 1'b0, 2'd0, 1'b0},  // R2 write-only refuses read
    {12'h600, 1'b0, 2'd0, 1'b0},  // R4 quarantine read
    {12'h600, 1'b1, 2'd0, 1'b0},  // R4 quarantine write
    {12'h800, 1'b0, 2'd1, 1'b1},  // R5 slot4 shares idx1
    {12'h800, 1'b1, 2'd0, 1'b0},  // R5 shared read-only
    {12'hA00, 1'b0, 2'd0, 1'b0},  // R5 unmapped slot5
    {12'hE00, 1'b1, 2'd0, 1'b0},  // R5 unmapped slot7
    {12'h1FF, 1'b0, 2'd3, 1'b1}   // R2 idx0 top of region
  };

  function automatic string vec_tag(input int i);
    case (i)
      2, 3:            return "R3";
      7, 8:            return "R4";
      9, 10, 11, 12:   return "R5";
      default:         return "R2";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One request with m_ready and dny_ready high; checks decision, forwarding, response and pulse
  task automatic req(input logic [11:0] a, input logic w, input logic [1:0] f,
                     input logic exp, input string tag);
    @(negedge clk);
    s_valid = 1'b1; s_addr = a; s_write = w; s_fmt = f;
    #1;
    check({31'd0, chk_pass}, {31'd0, exp}, tag);
    check({31'd0, m_valid}, {31'd0, exp}, "R6");
    if (exp) check({20'd0, m_addr}, {20'd0, a}, "R1");
    @(negedge clk);
    s_valid = 1'b0;
    check({31'd0, attack}, {31'd0, !exp}, "R7");
    check({31'd0, dny_valid}, {31'd0, !exp}, "R6");
    if (!exp) check({31'd0, dny_write}, {31'd0, w}, "R6");
  endtask

  task automatic cfg_write(input logic [1:0] i, input logic [31:0] w);
    @(negedge clk);
    cfg_hold = 1'b1; cfg_we = 1'b1; cfg_idx = i; cfg_word = w;
  endtask

  task automatic cfg_end();
    @(negedge clk);
    cfg_we = 1'b0; cfg_hold = 1'b0;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check({31'd0, dny_valid}, 32'd0, "R11");
    check({31'd0, attack}, 32'd0, "R11");
    check({31'd0, m_valid}, 32'd0, "R11");
    req(12'h600, 1'b1, 2'd3, 1'b1, "R11");

    // R10: write without hold is ignored
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_word = 32'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    req(12'h010, 1'b0, 2'd3, 1'b1, "R10");

    // R8: hold stalls an allowed request; no pulse, no response
    @(negedge clk);
    cfg_hold = 1'b1; s_valid = 1'b1; s_addr = 12'h010; s_write = 1'b0; s_fmt = 2'd0;
    #1;
    check({31'd0, m_valid}, 32'd0, "R8");
    check({31'd0, s_ready}, 32'd0, "R8");
    @(negedge clk);
    check({31'd0, attack}, 32'd0, "R8");
    check({31'd0, dny_valid}, 32'd0, "R8");
    s_valid = 1'b0;

    // R9: four policies in four consecutive cycles while held
    cfg_write(2'd0, 32'h0000_000F);
    cfg_write(2'd1, 32'h0000_0005);
    cfg_write(2'd2, 32'h0000_000E);
    cfg_write(2'd3, 32'h0000_0013);
    cfg_end();
    req(12'h210, 1'b1, 2'd0, 1'b0, "R9");

    for (int i = 0; i < 14; i++)
      req(VECS[i][15:4], VECS[i][3], VECS[i][2:1], VECS[i][0], vec_tag(i));

    // R1: slave back-pressure holds the allowed request
    @(negedge clk);
    m_ready = 1'b0; s_valid = 1'b1; s_addr = 12'h044; s_write = 1'b1; s_fmt = 2'd1;
    #1;
    check({31'd0, m_valid}, 32'd1, "R1");
    check({31'd0, s_ready}, 32'd0, "R1");
    check({30'd0, m_fmt}, 32'd1, "R1");
    check({31'd0, m_write}, 32'd1, "R1");
    @(negedge clk);
    s_valid = 1'b0; m_ready = 1'b1;

    // R6: error response held under back-pressure, second denial stalls
    dny_ready = 1'b0;
    @(negedge clk);
    s_valid = 1'b1; s_addr = 12'hA00; s_write = 1'b1; s_fmt = 2'd0;
    @(negedge clk);
    check({31'd0, attack}, 32'd1, "R7");
    check({31'd0, dny_valid}, 32'd1, "R6");
    check({30'd0, dny_resp}, 32'd2, "R6");
    check(dny_rdata, 32'd0, "R6");
    s_write = 1'b0;
    #1;
    check({31'd0, s_ready}, 32'd0, "R6");
    @(negedge clk);
    check({31'd0, attack}, 32'd0, "R7");
    check({31'd0, dny_write}, 32'd1, "R6");
    check({31'd0, dny_valid}, 32'd1, "R6");
    s_addr = 12'h010;
    #1;
    check({31'd0, s_ready}, 32'd1, "R6");
    check({31'd0, m_valid}, 32'd1, "R6");
    @(negedge clk);
    s_valid = 1'b0; dny_ready = 1'b1;
    @(negedge clk);
    check({31'd0, dny_valid}, 32'd0, "R6");

    // R12: reserved bits set force quarantine
    cfg_write(2'd0, 32'h0000_010F);
    cfg_end();
    req(12'h010, 1'b0, 2'd0, 1'b0, "R12");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule